// File: doc/BRIEF.md
# Multiply Result Interlock Unit

This block decides, one cycle at a time, whether the instruction waiting at the issue point of an in-order integer pipeline must be held back. The reason for holding it back is a multiply still in flight. When a multiply issues, the unit stores its destination register index and whether it updates the condition flags. It then loads a count of the cycles left before the result can be used. A full multiply waits three execute cycles plus one delay cycle. A multiply flagged as finishing early, because its operands are small, waits only the minimum delay.

The candidate instruction is presented every cycle with a valid bit, a multiply marker, its own destination, set-flags and early-finish bits, up to three source register indices each with an enable, and a flag-use bit. The stall request is combinational. It is raised only when the candidate truly depends on the pending multiply. Instructions that do not depend on it pass with no lost cycle. A register-to-itself move that names the pending destination counts as a reader. The program counter index never counts as a dependency. By default a flag-setting multiply holds every following instruction, conditional or not. A build option narrows this to instructions that consume flags. A second multiply waits until the first has drained. A flush clears all tracking.

Top module: `mul_interlock`

## Requirements
- R1: With no multiply pending, stall_o is 0. While a non-flag-setting multiply is pending, a valid non-multiply candidate with no enabled source equal to the pending destination is not stalled.
- R2: A full-latency multiply (early hint 0) that issues in cycle t makes a dependent candidate stall in cycles t+1 through t+4, exactly 4 cycles, and issue in cycle t+5.
- R3: A candidate stalls when any of its enabled source slots (0, 1 or 2) holds the pending destination index. This includes a move whose source and destination both equal that register.
- R4: While a flag-setting multiply is pending, every valid candidate stalls, whatever its sources and flag-use bit (default build, flag-block-all = 1).
- R5: A multiply candidate presented while another multiply is pending stalls. It issues once the first has completed, and its own latency then applies.
- R6: A multiply issued with the early hint set gives a dependent candidate exactly 1 stall cycle.
- R7: Asserting flush_i at a clock edge clears the pending multiply, so no candidate stalls in the following cycle. A multiply presented together with the flush is not tracked.
- R8: A source slot holding index 15 (program counter) never causes a stall, even when 15 is the pending destination.
- R9: An invalid candidate (cand_valid_i = 0) never stalls. A source slot whose enable bit is 0 causes no stall, whatever index it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Pipeline flush; clears pending multiply state |
| cand_valid_i | input | 1 | Candidate instruction is present |
| cand_is_mul_i | input | 1 | Candidate is a multiply |
| cand_dst_i | input | 4 | Candidate destination register index |
| cand_setf_i | input | 1 | Candidate multiply updates condition flags |
| cand_early_i | input | 1 | Candidate multiply finishes early (small operands) |
| cand_src_i | input | 12 | Three 4-bit source indices; slot k at bits 4k+3:4k |
| cand_src_en_i | input | 3 | Per-slot source enable; bit k enables slot k |
| cand_flag_use_i | input | 1 | Candidate reads condition flags |
| stall_o | output | 1 | Hold the candidate this cycle |

## Verification
The embedded properties check the following on every cycle: that an idle tracker or an invalid candidate never stalls, that a multiply never overtakes a pending one, that a flush empties the tracker, and that a reload lands on the full or the early count and then counts down by one. The exact number of stall cycles seen by a dependent instruction, the move-to-itself case, the program-counter exemption and the blocking of instructions that do not read the multiply's register after a flag-setting multiply only show up in the bench's scenarios. The bench runs those scenarios against its cycle model.

// File: rtl/mi_pkg.sv
package mi_pkg;
   // Width of a counter that holds values 0..max_val
   function automatic int cnt_width(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/mi_lat_track.sv
module mi_lat_track #(
   parameter int IDX_W    = 4,
   parameter int LAT_FULL = 4,
   parameter int LAT_MIN  = 1,
   parameter int CNT_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             load_i,
   input  logic             early_i,
   input  logic [IDX_W-1:0] dst_i,
   input  logic             setf_i,
   output logic             pend_o,
   output logic [IDX_W-1:0] dst_o,
   output logic             setf_o
);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LAT_FULL);
   localparam logic [CNT_W-1:0] CNT_MIN  = CNT_W'(LAT_MIN);

   logic [CNT_W-1:0] rem_q;
   logic [IDX_W-1:0] dst_q;
   logic             setf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         dst_q  <= '0;
         setf_q <= 1'b0;
      end else if (flush_i) begin
         rem_q  <= '0;
         setf_q <= 1'b0;
      end else if (load_i) begin
         rem_q  <= early_i ? CNT_MIN : CNT_FULL;
         dst_q  <= dst_i;
         setf_q <= setf_i;
      end else if (rem_q != '0) begin
         rem_q  <= rem_q - 1'b1;
      end
   end

   assign pend_o = (rem_q != '0);
   assign dst_o  = dst_q;
   assign setf_o = setf_q;

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !pend_o); // R7
   AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !early_i && !flush_i) |=> (rem_q == CNT_FULL)); // R2
   AST_LOAD_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && early_i && !flush_i) |=> (rem_q == CNT_MIN)); // R6
   AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o && !load_i && !flush_i) |=> (rem_q == $past(rem_q) - 1'b1)); // R2
   AST_NO_RELOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      pend_o |-> !load_i); // R5
endmodule

// File: rtl/mi_src_cmp.sv
module mi_src_cmp #(
   parameter int IDX_W   = 4,
   parameter int NUM_SRC = 3,
   parameter int PC_IDX  = 15
) (
   input  logic [NUM_SRC*IDX_W-1:0] src_i,
   input  logic [NUM_SRC-1:0]       en_i,
   input  logic [IDX_W-1:0]         dst_i,
   output logic                     hit_o
);
   localparam logic [IDX_W-1:0] PC_CODE = IDX_W'(PC_IDX);
   logic [NUM_SRC-1:0] slot_hit;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
      logic [IDX_W-1:0] idx;
      assign idx = src_i[g*IDX_W +: IDX_W];
      assign slot_hit[g] = en_i[g] && (idx == dst_i) && (idx != PC_CODE);
   end

   assign hit_o = |slot_hit;
endmodule

// File: rtl/mi_stall_mux.sv
module mi_stall_mux #(
   parameter bit FLAG_BLOCK_ALL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic valid_i,
   input  logic pend_i,
   input  logic setf_p_i,
   input  logic is_mul_i,
   input  logic flag_use_i,
   input  logic reg_hit_i,
   output logic stall_o
);
   logic flag_blk;

   if (FLAG_BLOCK_ALL) begin : g_flag_all
      assign flag_blk = setf_p_i;
   end else begin : g_flag_users
      assign flag_blk = setf_p_i && flag_use_i;
   end

   assign stall_o = valid_i && pend_i && (reg_hit_i || flag_blk || is_mul_i);

   AST_FLAG_READER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && pend_i && setf_p_i && flag_use_i) |-> stall_o); // R4
endmodule

// File: rtl/mul_interlock.sv
module mul_interlock #(
   parameter int IDX_W          = 4,
   parameter int NUM_SRC        = 3,
   parameter int LAT_FULL       = 4,
   parameter int LAT_MIN        = 1,
   parameter int PC_IDX         = 15,
   parameter bit FLAG_BLOCK_ALL = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush_i,
   input  logic                     cand_valid_i,
   input  logic                     cand_is_mul_i,
   input  logic [IDX_W-1:0]         cand_dst_i,
   input  logic                     cand_setf_i,
   input  logic                     cand_early_i,
   input  logic [NUM_SRC*IDX_W-1:0] cand_src_i,
   input  logic [NUM_SRC-1:0]       cand_src_en_i,
   input  logic                     cand_flag_use_i,
   output logic                     stall_o
);
   import mi_pkg::*;
   localparam int CNT_W = cnt_width(LAT_FULL);

   if (LAT_MIN < 1 || LAT_MIN > LAT_FULL) begin : g_bad_lat
      $error("mul_interlock: LAT_MIN must lie in 1..LAT_FULL");
   end
   if (PC_IDX < 0 || PC_IDX >= (1 << IDX_W)) begin : g_bad_pc
      $error("mul_interlock: PC_IDX outside register index range");
   end
   if (NUM_SRC < 1) begin : g_bad_src
      $error("mul_interlock: NUM_SRC must be at least 1");
   end

   logic             pend;
   logic [IDX_W-1:0] p_dst;
   logic             p_setf;
   logic             reg_hit;
   logic             load;

   assign load = cand_valid_i && cand_is_mul_i && !stall_o;

   mi_lat_track #(
      .IDX_W(IDX_W), .LAT_FULL(LAT_FULL), .LAT_MIN(LAT_MIN), .CNT_W(CNT_W)
   ) u_track (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .load_i(load),
      .early_i(cand_early_i), .dst_i(cand_dst_i), .setf_i(cand_setf_i),
      .pend_o(pend), .dst_o(p_dst), .setf_o(p_setf)
   );

   mi_src_cmp #(
      .IDX_W(IDX_W), .NUM_SRC(NUM_SRC), .PC_IDX(PC_IDX)
   ) u_cmp (
      .src_i(cand_src_i), .en_i(cand_src_en_i), .dst_i(p_dst), .hit_o(reg_hit)
   );

   mi_stall_mux #(
      .FLAG_BLOCK_ALL(FLAG_BLOCK_ALL)
   ) u_mux (
      .clk(clk), .rst_n(rst_n), .valid_i(cand_valid_i), .pend_i(pend),
      .setf_p_i(p_setf), .is_mul_i(cand_is_mul_i), .flag_use_i(cand_flag_use_i),
      .reg_hit_i(reg_hit), .stall_o(stall_o)
   );

   AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      !pend |-> !stall_o); // R1
   AST_INVALID_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      !cand_valid_i |-> !stall_o); // R9
   AST_MUL_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_valid_i && cand_is_mul_i && pend) |-> stall_o); // R5
endmodule

// File: tb/sim_mul_interlock.sv
module sim_mul_interlock;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush_i = 1'b0;
   logic        cand_valid_i = 1'b0;
   logic        cand_is_mul_i = 1'b0;
   logic [3:0]  cand_dst_i = '0;
   logic        cand_setf_i = 1'b0;
   logic        cand_early_i = 1'b0;
   logic [11:0] cand_src_i = '0;
   logic [2:0]  cand_src_en_i = '0;
   logic        cand_flag_use_i = 1'b0;
   logic        stall_o;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   bit last_stall;

   // reference model state
   int m_rem = 0;
   int m_dst = 0;
   bit m_setf = 1'b0;

   always #2 clk = ~clk;

   mul_interlock u0 (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .cand_valid_i(cand_valid_i),
      .cand_is_mul_i(cand_is_mul_i), .cand_dst_i(cand_dst_i), .cand_setf_i(cand_setf_i),
      .cand_early_i(cand_early_i), .cand_src_i(cand_src_i), .cand_src_en_i(cand_src_en_i),
      .cand_flag_use_i(cand_flag_use_i), .stall_o(stall_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit model_stall();
      bit hit = 1'b0;
      for (int k = 0; k < 3; k++) begin
         int idx = (cand_src_i >> (4 * k)) & 15;
         if (cand_src_en_i[k] && idx == m_dst && idx != 15) hit = 1'b1;
      end
      return cand_valid_i && (m_rem > 0) && (hit || m_setf || cand_is_mul_i);
   endfunction

   // one cycle: drive, compare against model, advance model, pass the edge
   task automatic cyc(input bit v, input bit mul, input int dst, input bit sf,
                      input bit early, input int s0, input int s1, input int s2,
                      input bit [2:0] en, input bit fuse, input bit fl, input string tag);
      bit exp;
      @(negedge clk);
      cand_valid_i = v; cand_is_mul_i = mul; cand_dst_i = 4'(dst);
      cand_setf_i = sf; cand_early_i = early;
      cand_src_i = {4'(s2), 4'(s1), 4'(s0)}; cand_src_en_i = en;
      cand_flag_use_i = fuse; flush_i = fl;
      #1;
      exp = model_stall();
      chk(stall_o === exp, tag, int'(stall_o), int'(exp));
      last_stall = stall_o;
      if (fl) begin
         m_rem = 0; m_setf = 1'b0;
      end else if (v && mul && !exp) begin
         m_rem = early ? 1 : 4; m_dst = dst; m_setf = sf;
      end else if (m_rem > 0) begin
         m_rem--;
      end
      @(posedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 3'b000, 0, 0, "R9 idle");
   endtask

   // count stall cycles of a reader of register r until it issues
   task automatic count_reader(input int r, input string tag, output int n);
      n = 0;
      for (int i = 0; i < 10; i++) begin
         cyc(1, 0, 1, 0, 0, r, 0, 0, 3'b001, 0, 0, tag);
         if (last_stall) n++;
         else break;
      end
   endtask

   initial begin
      int n;
      #1;
      chk(stall_o === 1'b0, "R1 reset state", int'(stall_o), 0);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      cyc(1, 0, 2, 0, 0, 3, 4, 5, 3'b111, 1, 0, "R1 no pending");

      // R2 full latency
      cyc(1, 1, 3, 0, 0, 1, 2, 0, 3'b011, 0, 0, "R2 mul issue");
      count_reader(3, "R2 dependent", n);
      chk(n == 4, "R2 stall count", n, 4);

      // R6 early finish
      cyc(1, 1, 6, 0, 1, 1, 2, 0, 3'b011, 0, 0, "R6 mul issue");
      count_reader(6, "R6 dependent", n);
      chk(n == 1, "R6 stall count", n, 1);

      // R3 self move as no-op, every slot
      cyc(1, 1, 0, 0, 0, 1, 2, 0, 3'b011, 0, 0, "R3 mul issue");
      cyc(1, 0, 0, 0, 0, 0, 0, 0, 3'b001, 0, 0, "R3 mov r0,r0");
      chk(last_stall === 1'b1, "R3 self move held", int'(last_stall), 1);
      cyc(1, 0, 7, 0, 0, 1, 2, 0, 3'b111, 0, 0, "R3 slot2 hit");
      chk(last_stall === 1'b1, "R3 slot2 held", int'(last_stall), 1);
      // R1 independent while pending
      cyc(1, 0, 7, 0, 0, 1, 2, 4, 3'b111, 1, 0, "R1 independent");
      chk(last_stall === 1'b0, "R1 independent free", int'(last_stall), 0);
      idle(4);

      // R4 flag-setting multiply blocks everything
      cyc(1, 1, 9, 1, 0, 1, 2, 0, 3'b011, 0, 0, "R4 muls issue");
      cyc(1, 0, 4, 0, 0, 1, 2, 0, 3'b011, 0, 0, "R4 non-reader");
      chk(last_stall === 1'b1, "R4 non-reader held", int'(last_stall), 1);
      cyc(1, 0, 4, 0, 0, 0, 0, 0, 3'b000, 1, 0, "R4 flag reader");
      chk(last_stall === 1'b1, "R4 flag reader held", int'(last_stall), 1);
      idle(3);
      cyc(1, 0, 4, 0, 0, 1, 2, 0, 3'b011, 0, 0, "R4 after drain");
      chk(last_stall === 1'b0, "R4 released", int'(last_stall), 0);

      // R5 back-to-back multiplies
      cyc(1, 1, 2, 0, 0, 1, 3, 0, 3'b011, 0, 0, "R5 first mul");
      n = 0;
      for (int i = 0; i < 10; i++) begin
         cyc(1, 1, 8, 0, 0, 4, 5, 0, 3'b011, 0, 0, "R5 second mul");
         if (last_stall) n++;
         else break;
      end
      chk(n == 4, "R5 second mul wait", n, 4);
      count_reader(8, "R5 second latency", n);
      chk(n == 4, "R5 second latency count", n, 4);

      // R8 program counter never a dependency
      cyc(1, 1, 15, 0, 0, 1, 2, 0, 3'b011, 0, 0, "R8 mul to pc");
      cyc(1, 0, 1, 0, 0, 15, 15, 15, 3'b111, 0, 0, "R8 pc source");
      chk(last_stall === 1'b0, "R8 pc source free", int'(last_stall), 0);
      idle(4);

      // R9 invalid candidate and disabled slots
      cyc(1, 1, 5, 0, 0, 1, 2, 0, 3'b011, 0, 0, "R9 mul issue");
      cyc(0, 0, 0, 0, 0, 5, 5, 5, 3'b111, 0, 0, "R9 invalid");
      chk(last_stall === 1'b0, "R9 invalid free", int'(last_stall), 0);
      cyc(1, 0, 1, 0, 0, 5, 5, 5, 3'b000, 0, 0, "R9 disabled slots");
      chk(last_stall === 1'b0, "R9 disabled free", int'(last_stall), 0);
      idle(3);

      // R7 flush
      cyc(1, 1, 4, 1, 0, 1, 2, 0, 3'b011, 0, 0, "R7 mul issue");
      cyc(1, 0, 1, 0, 0, 4, 0, 0, 3'b001, 0, 1, "R7 flush cycle");
      cyc(1, 0, 1, 0, 0, 4, 0, 0, 3'b001, 0, 0, "R7 after flush");
      chk(last_stall === 1'b0, "R7 cleared", int'(last_stall), 0);
      cyc(1, 1, 6, 1, 0, 1, 2, 0, 3'b011, 0, 1, "R7 mul with flush");
      cyc(1, 0, 1, 0, 0, 6, 0, 0, 3'b001, 0, 0, "R7 untracked");
      chk(last_stall === 1'b0, "R7 mul dropped", int'(last_stall), 0);

      idle(2);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule